// File: doc/BRIEF.md
# L2 Forwarding-Table Hash Index Generator

This block turns a 64-bit lookup key, built from a station MAC address and a VLAN ID, into the row address of a bucketed forwarding table. It cuts the key into six slices (five of 11 bits and a top one of 9 bits) and XOR-folds them into an 11-bit bucket hash. A mode input picks between a plain fold and a fold in which three of the slices are first rotated by different amounts, which scatters keys that differ only in a few bit positions.

Each bucket holds four entries. The block appends a caller-supplied 2-bit way number below the hash and clears the table-select bit at the top, so the result addresses the hashed SRAM and not the small associative table beside it. Keys enter on a valid/ready handshake, one per cycle, and each result leaves one cycle later from a register with its own valid flag. The mode bit travels with the key it was presented with.

Top module: `l2hash_index`

## Requirements
- R1: With `alg_sel_i` = 0 the hash equals key[10:0] ^ key[21:11] ^ key[32:22] ^ key[43:33] ^ key[54:44] ^ {2'b00, key[63:55]}.
- R2: With `alg_sel_i` = 1 the slice key[21:11] is rotated left by 6 within 11 bits, key[43:33] by 5 and key[54:44] by 4, and these three are XORed with key[10:0], key[32:22] and the zero-extended key[63:55].
- R3: The output row is laid out as: bits [1:0] = way number, bits [12:2] = hash, bit 13 = 0, bit 14 = 0 (hash SRAM selected).
- R4: A key accepted at a rising clock edge (valid and ready both high) yields its row on `idx_o` with `idx_valid_o` high right after the next... the same edge's register update, i.e. one cycle of latency.
- R5: After reset is released `key_ready_o` rises within a few cycles and then stays high, so a new key is taken every cycle.
- R6: The mode bit is taken with each key: back-to-back keys with alternating `alg_sel_i` each get the hash of their own mode.
- R7: While `rst_n` is low, `idx_valid_o` and `key_ready_o` are low.
- R8: In a cycle with no accepted key, `idx_valid_o` is low in the following cycle and `idx_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_valid_i | input | 1 | Key present |
| key_ready_o | output | 1 | Block can take a key this cycle |
| key_i | input | 64 | Lookup key (MAC and VLAN ID) |
| alg_sel_i | input | 1 | Hash mode: 0 plain fold, 1 rotated fold |
| way_i | input | 2 | Entry position inside the 4-entry bucket |
| idx_valid_o | output | 1 | `idx_o` holds a fresh result |
| idx_o | output | 15 | Table row address |

## Verification
The hardest situation to reach is a mode change between two keys taken on consecutive cycles, since a design that registers the mode separately or late still passes every test that holds the mode steady. The stimulus streams keys back to back while toggling `alg_sel_i` on each one, and mixes in keys with only single slices non-zero so a wrong rotation amount on any one slice shows up alone. All-zero and all-ones keys cover the folding of the short top slice, and idle gaps check that the output register holds.

// File: rtl/l2hash_pkg.sv
package l2hash_pkg;
  localparam int unsigned KEY_W  = 64;
  localparam int unsigned HASH_W = 11;
  localparam int unsigned WAY_W  = 2;
  localparam int unsigned N_SLC  = (KEY_W + HASH_W - 1) / HASH_W;
  localparam int unsigned ROW_W  = 15;
  localparam int unsigned TSEL_BIT = 14;

  typedef logic [HASH_W-1:0] hash_t;

  // Left-rotate amount applied to slice i in the rotated mode.
  function automatic int unsigned slice_rot(input int unsigned i);
    case (i)
      1: slice_rot = 6;
      3: slice_rot = 5;
      4: slice_rot = 4;
      default: slice_rot = 0;
    endcase
  endfunction
endpackage

// File: rtl/l2hash_rst_sync.sv
module l2hash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/l2hash_fold.sv
module l2hash_fold
  import l2hash_pkg::*;
#(
  parameter int unsigned KW = KEY_W,
  parameter int unsigned HW = HASH_W
) (
  input  logic [KW-1:0] key_i,
  input  logic          alg_i,
  output logic [HW-1:0] hash_o
);
  localparam int unsigned NS = (KW + HW - 1) / HW;

  logic [HW-1:0] term [NS];

  for (genvar g = 0; g < NS; g++) begin : g_slc
    localparam int unsigned LO  = g * HW;
    localparam int unsigned SW  = (LO + HW > KW) ? (KW - LO) : HW;
    localparam int unsigned ROT = slice_rot(g);
    logic [HW-1:0] raw;
    assign raw = HW'(key_i[LO +: SW]);
    if (ROT == 0) begin : g_plain
      assign term[g] = raw;
    end else begin : g_rot
      logic [HW-1:0] rotd;
      assign rotd    = {raw[HW-1-ROT:0], raw[HW-1 -: ROT]};
      assign term[g] = alg_i ? rotd : raw;
    end
  end

  always_comb begin
    hash_o = '0;
    for (int i = 0; i < NS; i++) hash_o = hash_o ^ term[i];
  end
endmodule

// File: rtl/l2hash_row_pack.sv
module l2hash_row_pack
  import l2hash_pkg::*;
#(
  parameter int unsigned HW   = HASH_W,
  parameter int unsigned WW   = WAY_W,
  parameter int unsigned RW   = ROW_W,
  parameter int unsigned SELB = TSEL_BIT
) (
  input  logic [HW-1:0] hash_i,
  input  logic [WW-1:0] way_i,
  output logic [RW-1:0] row_o
);
  always_comb begin
    row_o             = '0;
    row_o[WW-1:0]     = way_i;
    row_o[WW +: HW]   = hash_i;
    row_o[SELB]       = 1'b0;  // hashed SRAM, not the associative table
  end
endmodule

// File: rtl/l2hash_index.sv
module l2hash_index
  import l2hash_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid_i,
  output logic              key_ready_o,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              alg_sel_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic              idx_valid_o,
  output logic [ROW_W-1:0]  idx_o
);
  logic             rst_int_n;
  logic             rdy_q, rdy_d;
  logic             vld_q, vld_d;
  logic [ROW_W-1:0] row_q, row_d, row_new;
  hash_t            hash;
  logic             accept;

  l2hash_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  l2hash_fold #(.KW(KEY_W), .HW(HASH_W)) i_fold (
    .key_i(key_i), .alg_i(alg_sel_i), .hash_o(hash)
  );

  l2hash_row_pack #(.HW(HASH_W), .WW(WAY_W), .RW(ROW_W), .SELB(TSEL_BIT)) i_pack (
    .hash_i(hash), .way_i(way_i), .row_o(row_new)
  );

  assign accept = key_valid_i & rdy_q;

  always_comb begin
    rdy_d = 1'b1;
    vld_d = accept;
    row_d = row_q;
    if (accept) row_d = row_new;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdy_q <= 1'b0;
      vld_q <= 1'b0;
      row_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      vld_q <= vld_d;
      row_q <= row_d;
    end
  end

  assign key_ready_o = rdy_q;
  assign idx_valid_o = vld_q;
  assign idx_o       = row_q;
endmodule

// File: rtl/l2hash_index_chk.sv
module l2hash_index_chk
  import l2hash_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              key_valid_i,
  input logic              key_ready_o,
  input logic [WAY_W-1:0]  way_i,
  input logic              idx_valid_o,
  input logic [ROW_W-1:0]  idx_o
);
  assert_valid_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid_i && key_ready_o) |=> idx_valid_o);

  assert_way_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid_i && key_ready_o) |=> (idx_o[WAY_W-1:0] == $past(way_i)));

  assert_top_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid_o |-> (idx_o[TSEL_BIT:TSEL_BIT-1] == 2'b00));

  assert_ready_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready_o |=> key_ready_o);

  assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_valid_i && key_ready_o) |=> !idx_valid_o);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_valid_i && key_ready_o) |=> $stable(idx_o));

  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |-> (!idx_valid_o && !key_ready_o));
endmodule

bind l2hash_index l2hash_index_chk i_chk (.*);

// File: tb/test_l2hash_index.sv
module test_l2hash_index;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_valid_i = 1'b0;
  logic        key_ready_o;
  logic [63:0] key_i = '0;
  logic        alg_sel_i = 1'b0;
  logic [1:0]  way_i = '0;
  logic        idx_valid_o;
  logic [14:0] idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [14:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  l2hash_index i_l2hash_index (.*);

  function automatic logic [10:0] rl(input logic [10:0] v, input int n);
    logic [10:0] r = v;
    for (int k = 0; k < n; k++) r = {r[9:0], r[10]};
    return r;
  endfunction

  function automatic logic [14:0] model(input logic [63:0] k, input bit a, input logic [1:0] w);
    logic [10:0] s0, s1, s2, s3, s4, s5, h;
    s0 = k[10:0]; s1 = k[21:11]; s2 = k[32:22];
    s3 = k[43:33]; s4 = k[54:44]; s5 = {2'b00, k[63:55]};
    if (a) begin s1 = rl(s1, 6); s3 = rl(s3, 5); s4 = rl(s4, 4); end
    h = s0 ^ s1 ^ s2 ^ s3 ^ s4 ^ s5;
    return {2'b00, h, w};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: present at negedge, record expectation if taken at posedge.
  task automatic send(input logic [63:0] k, input bit a, input logic [1:0] w, input string req);
    @(negedge clk);
    key_valid_i = 1'b1; key_i = k; alg_sel_i = a; way_i = w;
    @(posedge clk);
    if (key_ready_o) begin
      exp_q.push_back(model(k, a, w));
      tag_q.push_back(req);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      key_valid_i = 1'b0;
      key_i = {$urandom, $urandom};
      alg_sel_i = $urandom;
      @(posedge clk);
    end
  endtask

  // Monitor: one cycle after each accept, the result must be valid and match.
  logic [14:0] last_idx;
  always @(negedge clk) begin
    #1;
    if (rst_n && key_ready_o) begin
      if (exp_q.size() > 0) begin
        logic [14:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(idx_valid_o === 1'b1, "R4 valid", 32'(idx_valid_o), 32'd1);
        check(idx_o === e, t, 32'(idx_o), 32'(e));
      end else begin
        check(idx_valid_o === 1'b0, "R8 no valid when idle", 32'(idx_valid_o), 32'd0);
        check(idx_o === last_idx, "R8 hold", 32'(idx_o), 32'(last_idx));
      end
      last_idx = idx_o;
    end
  end

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    last_idx = '0;
    repeat (3) @(negedge clk);
    check(idx_valid_o === 1'b0, "R7 valid in reset", 32'(idx_valid_o), 32'd0);
    check(key_ready_o === 1'b0, "R7 ready in reset", 32'(key_ready_o), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(key_ready_o === 1'b1, "R5 ready after reset", 32'(key_ready_o), 32'd1);
    last_idx = idx_o;

    send(64'h0, 0, 2'd0, "R1 zero key");
    send(64'h0, 1, 2'd3, "R2 zero key");
    send('1, 0, 2'd1, "R1 ones key");
    send('1, 1, 2'd2, "R2 ones key");
    idle(2);
    // single-slice keys isolate each rotation
    for (int s = 0; s < 6; s++) begin
      send(64'h1 << (s * 11), 0, 2'(s), "R1 single slice");
      send(64'h5 << (s * 11), 1, 2'(s), "R2 single slice");
    end
    idle(1);
    // mode toggling back to back
    for (int i = 0; i < 40; i++)
      send({$urandom, $urandom}, i[0], 2'($urandom), "R6 alternating mode");
    idle(3);
    for (int i = 0; i < 200; i++) begin
      send({$urandom, $urandom}, $urandom, 2'($urandom), "R3 random row");
      if (i % 17 == 0) idle(1);
    end
    idle(3);
    check(key_ready_o === 1'b1, "R5 ready stays", 32'(key_ready_o), 32'd1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule